// File: doc/BRIEF.md
# Link Activity Detector

This block decides whether a video link is carrying live traffic. It watches only the data-enable strobe, sampled on the pixel clock, and raises a detect flag while data enable keeps toggling. After a long stretch with no toggling at all, the flag drops and the link is reported lost. Recovery uses a separate, much tighter test: two toggles that land close together. The two tests are deliberately asymmetric.

The detect flag also drives a per-group driver-enable mask. When the link is down, the mask switches off every pixel, clock, sync and data-enable driver. The low-order control bit and the detect flag itself keep their drivers on, so that the downstream logic can still see the link state. The quiet timeout and the recovery window are both parameters. The defaults are one million clocks and 1024 clocks.

Top module: `link_sense_top`

## Requirements
- R1: After a synchronous reset, `link_detect` is 0 and `drv_en` is 9'h180.
- R2: While `link_detect` is 0, a second data-enable transition that is registered no more than WINDOW_CYCLES clocks after the first one sets `link_detect` to 1. `de_in` passes through two flops before its transitions are compared. As a result, `link_detect` rises at the third rising clock edge after the input change that forms the second transition.
- R3: While `link_detect` is 0, a lone transition with no partner inside the window leaves `link_detect` at 0.
- R4: While `link_detect` is 1, every transition restarts the quiet count. A link that toggles at least once every QUIET_CYCLES clocks stays up.
- R5: `link_detect` falls at the clock edge where QUIET_CYCLES consecutive clocks have passed with no registered transition. The count starts from the clock that registered the last transition.
- R6: The window is inclusive at its far end. A second transition exactly WINDOW_CYCLES clocks after the first restores the link. One at WINDOW_CYCLES+1 clocks does not.
- R7: A transition that arrives after the window has run out opens a fresh window. A following transition within WINDOW_CYCLES clocks of that late transition restores the link.
- R8: `drv_en` has 9 bits, one per driver group:
  - bit 0: even pixel bus
  - bit 1: odd pixel bus
  - bit 2: output clock
  - bit 3: horizontal sync
  - bit 4: vertical sync
  - bit 5: data enable
  - bit 6: control bits 2 and 3
  - bit 7: control bit 1
  - bit 8: the detect driver

  Bits 7 and 8 are always 1. Bits 0 to 6 equal `link_detect`, so `drv_en` is 9'h1FF when the link is up and 9'h180 when it is down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| de_in | input | 1 | Data-enable strobe, may be asynchronous to clk |
| link_detect | output | 1 | 1 when the link is judged active |
| drv_en | output | 9 | Driver-enable mask per output group, see R8 |

## Verification
The assertions assume that `de_in` is held low during reset. The synchronizer also resets low, so no transition is registered in the first cycles after reset. The assertions also assume that `de_in` changes at most once per clock period. Otherwise a double change would cancel out inside the synchronizer, and the quiet and window counts would not match the input pattern.

The stimulus meets both assumptions. It drives `de_in` only on falling clock edges, keeps it at 0 throughout reset, and toggles it at most once per cycle. The bench uses a small quiet timeout and a small window so that both limits, and the inclusive window boundary, are reached within a short run.

// File: rtl/link_sense_pkg.sv
// Shared constants for the link activity detector: driver group indices
// and the rule deciding which groups stay powered when the link is down.
package link_sense_pkg;

    localparam int DRV_PIX_EVEN = 0;
    localparam int DRV_PIX_ODD  = 1;
    localparam int DRV_OCLK     = 2;
    localparam int DRV_HSYNC    = 3;
    localparam int DRV_VSYNC    = 4;
    localparam int DRV_DE       = 5;
    localparam int DRV_CTL_HI   = 6;
    localparam int DRV_CTL1     = 7;
    localparam int DRV_DETECT   = 8;
    localparam int DRV_W        = 9;

    // Groups whose drivers ignore the link state.
    function automatic logic keeps_on(input int idx);
        return (idx == DRV_CTL1) || (idx == DRV_DETECT);
    endfunction

endpackage

// File: rtl/link_de_sync.sv
// Brings the data-enable strobe into the pixel clock domain and flags
// each change of level.
// Assumes de_in changes at most once per clock period.
// Reset clears the shift chain to low.
module link_de_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic de_in,
    output logic de_edge
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift chain: SYNC_STAGES synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], de_in};
    end

    assign de_edge = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];

endmodule

// File: rtl/link_quiet_timer.sv
// Counts clocks with no data-enable transition while the link is up.
// Pulses expire on the clock that completes LIMIT quiet clocks.
// Assumes run drops on the clock after expire.
module link_quiet_timer #(
    parameter int unsigned LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic evt,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Quiet counter: cleared by any transition or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || evt) cnt <= '0;
        else if (cnt == LAST)      cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign expire = run && !evt && (cnt == LAST);

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && evt) |=> (cnt == '0));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/link_recovery_window.sv
// While the link is down, arms on one transition and reports a pair when
// a second transition arrives no more than LIMIT clocks later.
// A window that runs out disarms, and the next transition re-arms it.
module link_recovery_window #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic evt,
    output logic pair_seen
);

    localparam int WW = $clog2(LIMIT + 1);
    localparam logic [WW-1:0] LAST = WW'(LIMIT - 1);

    logic          armed;
    logic [WW-1:0] wcnt;

    // Window state: arm on first transition, age, disarm at the far end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            armed <= 1'b0;
            wcnt  <= '0;
        end else if (evt) begin
            armed <= !armed;
            wcnt  <= '0;
        end else if (armed) begin
            if (wcnt == LAST) begin
                armed <= 1'b0;
                wcnt  <= '0;
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

    assign pair_seen = enable && armed && evt;

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= LAST);

    assert_arm_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(evt && enable));

endmodule

// File: rtl/link_sense_top.sv
// Link activity detector. Holds the link state flag and expands it into
// the driver-enable mask.
// Assumes de_in is low during reset.
module link_sense_top
    import link_sense_pkg::*;
#(
    parameter int unsigned QUIET_CYCLES  = 1000000,
    parameter int unsigned WINDOW_CYCLES = 1024,
    parameter int          SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_in,
    output logic             link_detect,
    output logic [DRV_W-1:0] drv_en
);

    logic edge_seen;
    logic expire;
    logic pair_seen;
    logic link_up;

    link_de_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .de_in   (de_in),
        .de_edge (edge_seen)
    );

    link_quiet_timer #(.LIMIT(QUIET_CYCLES)) quiet_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (link_up),
        .evt    (edge_seen),
        .expire (expire)
    );

    link_recovery_window #(.LIMIT(WINDOW_CYCLES)) window_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!link_up),
        .evt       (edge_seen),
        .pair_seen (pair_seen)
    );

    // Link state: dropped by the quiet timer, restored by a transition pair.
    always_ff @(posedge clk) begin
        if (!rst_n)         link_up <= 1'b0;
        else if (expire)    link_up <= 1'b0;
        else if (pair_seen) link_up <= 1'b1;
    end

    assign link_detect = link_up;

    // One enable per driver group.
    for (genvar i = 0; i < DRV_W; i++) begin : g_drv
        assign drv_en[i] = keeps_on(i) ? 1'b1 : link_up;
    end

    assert_rise_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(edge_seen));

    assert_fall_when_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up) |-> !$past(edge_seen));

endmodule

// File: tb/link_sense_top_tb_top.sv
// Bench for the link activity detector.
// A behavioural reference model is compared with the outputs on every clock.
module link_sense_top_tb_top;

    localparam int Q = 40;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       de = 1'b0;
    logic       link_detect;
    logic [8:0] drv_en;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string tag = "R1";

    // Reference model state.
    bit hist[$];
    int k = 0;
    int last_edge = 0;
    int first_edge = 0;
    bit armed = 0;
    bit m_up = 0;

    always #10 clk = ~clk;

    link_sense_top #(.QUIET_CYCLES(Q), .WINDOW_CYCLES(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .de_in       (de),
        .link_detect (link_detect),
        .drv_en      (drv_en)
    );

    function automatic bit hv(int i);
        return (i < 0) ? 1'b0 : hist[i];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model. A transition is registered two clocks after the input sample.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            k = 0;
            armed = 0;
            m_up = 0;
        end else begin
            bit tr;
            hist.push_back(de);
            tr = hv(k - 2) != hv(k - 3);
            if (tr) begin
                if (m_up) last_edge = k;
                else if (armed && (k - first_edge) <= W) begin
                    m_up = 1;
                    armed = 0;
                    last_edge = k;
                end else begin
                    armed = 1;
                    first_edge = k;
                end
            end else if (m_up && (k - last_edge) >= Q) begin
                m_up = 0;
            end
            k++;
        end
    end

    // Compare the outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(link_detect == m_up, {tag, " detect"}, link_detect, m_up);
            check(drv_en == (m_up ? 9'h1FF : 9'h180), "R8 mask", drv_en,
                  m_up ? 9'h1FF : 9'h180);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle();
        de = ~de;
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        check(link_detect == 1'b0, "R1 reset detect", link_detect, 0);
        check(drv_en == 9'h180, "R1 reset mask", drv_en, 9'h180);

        tag = "R3";
        toggle(); tick(60);
        check(link_detect == 1'b0, "R3 lone transition", link_detect, 0);

        tag = "R2";
        toggle(); tick(5); toggle(); tick(3);
        check(link_detect == 1'b1, "R2 pair restores", link_detect, 1);
        check(drv_en == 9'h1FF, "R8 mask up", drv_en, 9'h1FF);

        tag = "R4";
        for (int i = 0; i < 10; i++) begin
            tick(Q - 5); toggle();
        end
        tick(3);
        check(link_detect == 1'b1, "R4 kept alive", link_detect, 1);

        tag = "R5";
        tick(Q + 5);
        check(link_detect == 1'b0, "R5 quiet drop", link_detect, 0);
        check(drv_en == 9'h180, "R8 mask down", drv_en, 9'h180);

        tag = "R6";
        toggle(); tick(W); toggle(); tick(3);
        check(link_detect == 1'b1, "R6 exact window", link_detect, 1);
        tick(Q + 5);
        check(link_detect == 1'b0, "R5 second drop", link_detect, 0);
        toggle(); tick(W + 1); toggle(); tick(3);
        check(link_detect == 1'b0, "R6 window plus one", link_detect, 0);

        tag = "R7";
        tick(5); toggle(); tick(3);
        check(link_detect == 1'b1, "R7 restarted window", link_detect, 1);

        tag = "R2";
        tick(Q + 5);
        toggle(); tick(1); toggle(); tick(3);
        check(link_detect == 1'b1, "R2 back-to-back pair", link_detect, 1);
        tick(5);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule